// File: doc/BRIEF.md
# SDRAM Mode Register Programming Unit

This block sits on the command side of a low-power DDR memory model or controller. On every rising clock edge it samples the registered command pins, the bank address and a 13-bit address bus. When it sees a mode-register write, it uses the bank address to pick the target: the base configuration register or the extended configuration register. It then decodes the address bits into the settings that the rest of the memory path uses. The base register holds burst length, burst ordering and read latency. The extended register holds the self-refresh array coverage and the output drive strength.

The block checks every write before applying it. A write is refused if it arrives while any bank is open, if it names an undefined register, if it carries a reserved code or a set must-be-zero bit, or if it lands inside the settle window that follows an accepted write. A refused write leaves both registers unchanged and raises a one-cycle error pulse. Any write to the base register also returns the extended register to its power-on defaults. Because the base register has no defined power-up content, a validity flag marks when it has been programmed.

Top module: `mode_reg_prog_unit`

## Requirements
- R1: A write is recognised only when chip select, RAS, CAS and WE are all sampled low with clock enable high in both the current and the previous cycle. Any other pin combination leaves the registers and the error outputs unchanged.
- R2: Bank address 00 selects the base register and 10 selects the extended register. Codes 01 and 11 are refused with an `err_illegal` pulse and change nothing.
- R3: Base bits 2..0 set `bl_beats` to 2, 4, 8 or 16 for codes 001, 010, 011 and 100. Every other code is refused with `err_reserved`. While `base_valid` is high, `bl_beats` is one of those four values.
- R4: Base bit 3 drives `burst_interleave` (0 sequential, 1 interleaved). Base bits 6..4 set `cas_lat` to 2 for code 010 and 3 for code 011. Other latency codes are refused with `err_reserved`.
- R5: Extended bits 2..0 set `refresh_area` to 0 (full), 1 (half) or 2 (quarter) for codes 000, 001 and 010. Other codes are refused with `err_reserved`. Extended bits 6..5 are copied to `drive_str` (0 full, 1 half, 2 quarter, 3 eighth). A non-zero extended bit 3, 4 or 7..12 is refused with `err_reserved`.
- R6: An accepted base write sets the extended settings back to `drive_str`=1 and `refresh_area`=0 in the same edge.
- R7: A base write with any of bits 12..7 set is refused with `err_reserved` and changes nothing.
- R8: A write sampled while `banks_idle` is low is refused with `err_illegal` and changes nothing.
- R9: After an accepted write, `settle_busy` is high for SETTLE_CYC-1 cycles (one with the default of 2). A command other than NOP (chip select low and RAS, CAS and WE not all high) in that window raises `err_timing`, and a write in that window is refused. A write two cycles after the accepted one is accepted.
- R10: After reset, `base_valid` is 0, `drive_str` is 1, `refresh_area` is 0, and `settle_busy` and all error outputs are 0. `base_valid` rises after the first accepted base write and stays high.
- R11: Errors are one-cycle pulses in the cycle after the offending command, and at most one is high at a time. The priority is timing first, then illegal (bank state or bank code), then reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, selects target register |
| addr | input | 13 | Address bus carrying the operand |
| banks_idle | input | 1 | High when every bank is precharged |
| bl_beats | output | 5 | Burst length in beats |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| cas_lat | output | 2 | Read latency in cycles |
| base_valid | output | 1 | Base register has been programmed |
| refresh_area | output | 2 | Self-refresh coverage: 0 full, 1 half, 2 quarter |
| drive_str | output | 2 | Drive strength: 0 full, 1 half, 2 quarter, 3 eighth |
| settle_busy | output | 1 | Inside the settle window after a write |
| err_reserved | output | 1 | Pulse: reserved code or must-be-zero bit set |
| err_illegal | output | 1 | Pulse: banks not idle or undefined register |
| err_timing | output | 1 | Pulse: command inside settle window |

## Verification
Some properties are checked on every cycle. A write refused for open banks or for settle timing leaves the configuration stable. The settle window opens after each accepted write. `base_valid` never falls once set, and a valid burst length is always one of the four legal values. An accepted base write is followed by the extended defaults. Other behaviour can only be shown by the directed scenarios: the decoded value of each field code, which register a bank address selects, the rejection of each reserved code and must-be-zero bit, the clock-enable history needed for recognition, and the error priority when several faults coincide.

// File: rtl/mrpu_pkg.sv
package mrpu_pkg;

  typedef struct packed {
    logic [4:0] beats;
    logic       interleave;
    logic [1:0] cas_lat;
  } base_cfg_t;

  typedef struct packed {
    logic [1:0] area;
    logic [1:0] drive;
  } ext_cfg_t;

  localparam ext_cfg_t EXT_DEFAULT = '{area: 2'd0, drive: 2'd1};
  localparam base_cfg_t BASE_RESET = '{beats: 5'd2, interleave: 1'b0, cas_lat: 2'd2};

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RSVD    = 2'd1,
    ERR_ILLEGAL = 2'd2,
    ERR_TIMING  = 2'd3
  } err_e;

endpackage

// File: rtl/mrpu_cmd_decode.sv
module mrpu_cmd_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic mrs_hit,
  output logic cmd_hit
);

  logic cke_q;
  logic cke_d;
  logic pins_live;

  always_comb begin
    cke_d     = cke;
    pins_live = cke_q & cke & ~cs_n;
    mrs_hit   = pins_live & ~ras_n & ~cas_n & ~we_n;
    cmd_hit   = pins_live & ~(ras_n & cas_n & we_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  // R1
  cke_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_hit |-> $past(cke));

endmodule

// File: rtl/mrpu_settle.sv
module mrpu_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  generate
    if (SETTLE_CYC > 1) begin : g_timer
      localparam int CNT_W = $clog2(SETTLE_CYC);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = start | (cnt_q != '0);
        if (start) cnt_d = LOAD;
        else       cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy = (cnt_q != '0);

      // R9
      window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end else begin : g_none
      assign busy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/mrpu_field_check.sv
module mrpu_field_check
  import mrpu_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_ext,
  output base_cfg_t         base_dec,
  output ext_cfg_t          ext_dec,
  output logic              rsvd
);

  localparam int BL_LO   = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LO   = 4;
  localparam int DS_LO   = 5;
  localparam int MBZ_LO  = 7;

  logic       bl_ok, cl_ok, area_ok;
  logic       base_mbz, ext_mbz;
  logic [2:0] bl_code, cl_code, area_code;

  always_comb begin
    bl_code   = addr[BL_LO +: 3];
    cl_code   = addr[CL_LO +: 3];
    area_code = addr[BL_LO +: 3];

    bl_ok = 1'b1;
    base_dec.beats = 5'd2;
    case (bl_code)
      3'b001:  base_dec.beats = 5'd2;
      3'b010:  base_dec.beats = 5'd4;
      3'b011:  base_dec.beats = 5'd8;
      3'b100:  base_dec.beats = 5'd16;
      default: bl_ok = 1'b0;
    endcase

    cl_ok = 1'b1;
    base_dec.cas_lat = 2'd2;
    case (cl_code)
      3'b010:  base_dec.cas_lat = 2'd2;
      3'b011:  base_dec.cas_lat = 2'd3;
      default: cl_ok = 1'b0;
    endcase
    base_dec.interleave = addr[BT_BIT];

    area_ok = 1'b1;
    ext_dec.area = 2'd0;
    case (area_code)
      3'b000:  ext_dec.area = 2'd0;
      3'b001:  ext_dec.area = 2'd1;
      3'b010:  ext_dec.area = 2'd2;
      default: area_ok = 1'b0;
    endcase
    ext_dec.drive = addr[DS_LO +: 2];

    base_mbz = |addr[ADDR_W-1:MBZ_LO];
    ext_mbz  = base_mbz | (|addr[DS_LO-1:BT_BIT]);

    if (is_ext) rsvd = ~area_ok | ext_mbz;
    else        rsvd = ~bl_ok | ~cl_ok | base_mbz;
  end

endmodule

// File: rtl/mode_reg_prog_unit.sv
module mode_reg_prog_unit
  import mrpu_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic [4:0]        bl_beats,
  output logic              burst_interleave,
  output logic [1:0]        cas_lat,
  output logic              base_valid,
  output logic [1:0]        refresh_area,
  output logic [1:0]        drive_str,
  output logic              settle_busy,
  output logic              err_reserved,
  output logic              err_illegal,
  output logic              err_timing
);

  localparam logic [BA_W-1:0] BA_BASE = '0;
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1) << (BA_W - 1);

  logic      mrs_hit, cmd_hit;
  logic      sel_base, sel_ext, rsvd;
  logic      wr_base, wr_ext, cfg_en;
  base_cfg_t base_dec, base_q, base_d;
  ext_cfg_t  ext_dec, ext_q, ext_d;
  logic      valid_q, valid_d;
  err_e      err_q, err_d;

  mrpu_cmd_decode u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .mrs_hit (mrs_hit),
    .cmd_hit (cmd_hit)
  );

  mrpu_field_check #(.ADDR_W(ADDR_W)) u_fields (
    .addr     (addr),
    .is_ext   (sel_ext),
    .base_dec (base_dec),
    .ext_dec  (ext_dec),
    .rsvd     (rsvd)
  );

  mrpu_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cfg_en),
    .busy  (settle_busy)
  );

  always_comb begin
    sel_base = (ba == BA_BASE);
    sel_ext  = (ba == BA_EXT);
    err_d    = ERR_NONE;
    wr_base  = 1'b0;
    wr_ext   = 1'b0;
    if (cmd_hit && settle_busy) begin
      err_d = ERR_TIMING;
    end else if (mrs_hit) begin
      if (!banks_idle || !(sel_base || sel_ext)) err_d = ERR_ILLEGAL;
      else if (rsvd)                             err_d = ERR_RSVD;
      else begin
        wr_base = sel_base;
        wr_ext  = sel_ext;
      end
    end
    cfg_en  = wr_base | wr_ext;
    base_d  = wr_base ? base_dec : base_q;
    ext_d   = wr_base ? EXT_DEFAULT : (wr_ext ? ext_dec : ext_q);
    valid_d = valid_q | wr_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= BASE_RESET;
      ext_q   <= EXT_DEFAULT;
      valid_q <= 1'b0;
    end else if (cfg_en) begin
      base_q  <= base_d;
      ext_q   <= ext_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= ERR_NONE;
    else        err_q <= err_d;
  end

  assign bl_beats         = base_q.beats;
  assign burst_interleave = base_q.interleave;
  assign cas_lat          = base_q.cas_lat;
  assign base_valid       = valid_q;
  assign refresh_area     = ext_q.area;
  assign drive_str        = ext_q.drive;
  assign err_reserved     = (err_q == ERR_RSVD);
  assign err_illegal      = (err_q == ERR_ILLEGAL);
  assign err_timing       = (err_q == ERR_TIMING);

  // R8
  busy_banks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_hit && !banks_idle) |=> ($stable(base_q) && $stable(ext_q) &&
                                  (err_illegal || err_timing)));

  // R9
  settle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_hit && settle_busy) |=> (err_timing && $stable(base_q) && $stable(ext_q)));

  // R6
  ext_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (drive_str == 2'd1 && refresh_area == 2'd0));

  // R10
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid |=> base_valid);

  // R3
  burst_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid |-> ($onehot(bl_beats) && !bl_beats[0]));

endmodule

// File: tb/test_mode_reg_prog_unit.sv
module test_mode_reg_prog_unit;

  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n, banks_idle;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [4:0]  bl_beats;
  logic        burst_interleave, base_valid, settle_busy;
  logic [1:0]  cas_lat, refresh_area, drive_str;
  logic        err_reserved, err_illegal, err_timing;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int e_bl = 2, e_il = 0, e_cl = 2, e_area = 0, e_drv = 1;

  always #5 clk = ~clk;

  mode_reg_prog_unit i_mode_reg_prog_unit (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .bl_beats(bl_beats), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .base_valid(base_valid), .refresh_area(refresh_area), .drive_str(drive_str),
    .settle_busy(settle_busy), .err_reserved(err_reserved),
    .err_illegal(err_illegal), .err_timing(err_timing)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_errs(input string req, input int r, input int i, input int t);
    chk(req, "err_reserved", err_reserved, r);
    chk(req, "err_illegal", err_illegal, i);
    chk(req, "err_timing", err_timing, t);
  endtask

  task automatic chk_cfg(input string req);
    chk(req, "bl_beats", bl_beats, e_bl);
    chk(req, "burst_interleave", burst_interleave, e_il);
    chk(req, "cas_lat", cas_lat, e_cl);
    chk(req, "refresh_area", refresh_area, e_area);
    chk(req, "drive_str", drive_str, e_drv);
  endtask

  task automatic nop();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'b00; addr = '0; banks_idle = 1'b1;
  endtask

  task automatic set_mrs(input logic [1:0] b, input logic [12:0] a, input logic idle);
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
    ba = b; addr = a; banks_idle = idle;
  endtask

  // Starts and ends at a falling edge; returns in the cycle after the write.
  task automatic do_mrs(input logic [1:0] b, input logic [12:0] a, input logic idle);
    set_mrs(b, a, idle);
    @(posedge clk);
    @(negedge clk);
    nop();
  endtask

  task automatic gap();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "base_valid", base_valid, 0);
    chk("R10", "drive_str", drive_str, 1);
    chk("R10", "refresh_area", refresh_area, 0);
    chk("R10", "settle_busy", settle_busy, 0);
    chk_errs("R10", 0, 0, 0);
  endtask

  task automatic t_recognise();
    // cke rises in the same cycle as the write: ignored
    cke = 1'b1;
    do_mrs(2'b00, 13'h032, 1'b1);
    chk("R1", "base_valid after fresh cke", base_valid, 0);
    chk_errs("R1", 0, 0, 0);
    // chip select high
    cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; addr = 13'h032;
    @(posedge clk); @(negedge clk); nop();
    chk("R1", "base_valid cs high", base_valid, 0);
    chk("R1", "settle_busy cs high", settle_busy, 0);
    // cke low in the write cycle
    cke = 1'b0;
    do_mrs(2'b00, 13'h032, 1'b1);
    chk("R1", "base_valid cke low", base_valid, 0);
    chk_errs("R1", 0, 0, 0);
    cke = 1'b1;
    gap();
    chk_cfg("R1");
  endtask

  task automatic t_base();
    do_mrs(2'b00, 13'h032, 1'b1);  // BL4 seq CL3
    e_bl = 4; e_il = 0; e_cl = 3;
    chk_cfg("R3");
    chk("R10", "base_valid", base_valid, 1);
    chk("R9", "settle_busy", settle_busy, 1);
    chk_errs("R3", 0, 0, 0);
    gap();
    chk("R9", "settle_busy cleared", settle_busy, 0);
    do_mrs(2'b00, 13'h02C, 1'b1);  // BL16 interleave CL2
    e_bl = 16; e_il = 1; e_cl = 2;
    chk_cfg("R4");
    gap();
    do_mrs(2'b00, 13'h033, 1'b1);  // BL8
    e_bl = 8; e_il = 0; e_cl = 3;
    chk_cfg("R3");
    gap();
    do_mrs(2'b00, 13'h029, 1'b1);  // BL2 interleave CL2
    e_bl = 2; e_il = 1; e_cl = 2;
    chk_cfg("R3");
    gap();
  endtask

  task automatic t_ext();
    do_mrs(2'b10, 13'h062, 1'b1);  // eighth drive, quarter area
    e_drv = 3; e_area = 2;
    chk_cfg("R5");
    chk_errs("R5", 0, 0, 0);
    gap();
    do_mrs(2'b10, 13'h021, 1'b1);
    e_drv = 1; e_area = 1;
    chk_cfg("R2");
    gap();
    do_mrs(2'b10, 13'h040, 1'b1);
    e_drv = 2; e_area = 0;
    chk_cfg("R5");
    gap();
  endtask

  task automatic t_ext_reset();
    do_mrs(2'b10, 13'h042, 1'b1);
    e_drv = 2; e_area = 2;
    chk_cfg("R5");
    gap();
    do_mrs(2'b00, 13'h032, 1'b1);
    e_bl = 4; e_il = 0; e_cl = 3; e_drv = 1; e_area = 0;
    chk_cfg("R6");
    gap();
  endtask

  task automatic t_reserved();
    do_mrs(2'b00, 13'h030, 1'b1);  // BL code 000
    chk_errs("R3", 1, 0, 0); chk_cfg("R3");
    chk("R3", "settle_busy", settle_busy, 0);
    gap();
    do_mrs(2'b00, 13'h035, 1'b1);  // BL code 101
    chk_errs("R3", 1, 0, 0); chk_cfg("R3");
    gap();
    do_mrs(2'b00, 13'h012, 1'b1);  // CL code 001
    chk_errs("R4", 1, 0, 0); chk_cfg("R4");
    gap();
    do_mrs(2'b00, 13'h0B2, 1'b1);  // bit 7 set
    chk_errs("R7", 1, 0, 0); chk_cfg("R7");
    gap();
    do_mrs(2'b00, 13'h1032, 1'b1); // bit 12 set
    chk_errs("R7", 1, 0, 0); chk_cfg("R7");
    gap();
    do_mrs(2'b10, 13'h003, 1'b1);  // area code 011
    chk_errs("R5", 1, 0, 0); chk_cfg("R5");
    gap();
    do_mrs(2'b10, 13'h008, 1'b1);  // bit 3 set
    chk_errs("R5", 1, 0, 0); chk_cfg("R5");
    gap();
    chk_errs("R11", 0, 0, 0);
  endtask

  task automatic t_bank_and_idle();
    do_mrs(2'b01, 13'h062, 1'b1);
    chk_errs("R2", 0, 1, 0); chk_cfg("R2");
    gap();
    do_mrs(2'b11, 13'h02C, 1'b1);
    chk_errs("R2", 0, 1, 0); chk_cfg("R2");
    gap();
    do_mrs(2'b00, 13'h02C, 1'b0);
    chk_errs("R8", 0, 1, 0); chk_cfg("R8");
    chk("R8", "settle_busy", settle_busy, 0);
    gap();
    do_mrs(2'b00, 13'h030, 1'b0);  // reserved and not idle: illegal wins
    chk_errs("R11", 0, 1, 0);
    gap();
  endtask

  task automatic t_settle();
    do_mrs(2'b00, 13'h033, 1'b1);
    e_bl = 8; e_il = 0; e_cl = 3; e_drv = 1; e_area = 0;
    chk("R9", "settle_busy", settle_busy, 1);
    set_mrs(2'b10, 13'h062, 1'b0);  // inside window, also not idle
    @(posedge clk); @(negedge clk); nop();
    chk_errs("R11", 0, 0, 1);
    chk_cfg("R9");
    chk("R9", "settle_busy after window", settle_busy, 0);
    set_mrs(2'b10, 13'h062, 1'b1);  // two cycles after accepted write
    @(posedge clk); @(negedge clk); nop();
    e_drv = 3; e_area = 2;
    chk_cfg("R9");
    chk_errs("R9", 0, 0, 0);
    // non-write command in the window
    cs_n = 1'b0; ras_n = 1'b0;
    @(posedge clk); @(negedge clk); nop();
    chk_errs("R9", 0, 0, 1);
    gap();
    chk_errs("R11", 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; cke = 1'b0;
    nop();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_recognise();
    t_base();
    t_ext();
    t_ext_reset();
    t_reserved();
    t_bank_and_idle();
    t_settle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule